// File: doc/BRIEF.md
# Multichannel DAC Code Trim Path

This block is the digital correction stage in front of a multichannel voltage DAC. Every channel keeps three registers of its own: the raw input code, a gain coefficient and an offset coefficient. From these it forms a trimmed code, x2 = floor(x1 * (m + 2) / 2^n) + c - 2^(n-1), where n is the DAC resolution. The trimmed code is clamped to the valid code range.

Each channel has two stages. A write to any coefficient changes the trimmed code combinationally. The code reaches the output register of a channel only when the shared load strobe is pulsed, so every channel moves on the same clock edge. A load in the same cycle as a write picks up the value just written.

Software-facing plumbing such as a serial link is outside this block. The block sees a plain write port (channel, register select, data), a load strobe, and one flat bus that carries the codes of all channels.

Top module: `dac_trim_top`

## Requirements
- R1: After a load, a channel's output equals floor(x1 * (m + 2) / 2^RES_W) + c - 2^(RES_W-1). The division truncates toward zero.
- R2: Reset clears the input registers and output registers to 0. It sets every gain to 2^RES_W - 2 (0x3FFE at 14 bits) and every offset to 2^(RES_W-1) (0x2000 at 14 bits), so an untouched channel passes x1 through unchanged.
- R3: The trimmed code is clamped: a negative result gives 0, and a result above 2^RES_W - 1 gives 2^RES_W - 1.
- R4: Bit 0 of the written data is forced to 0 when the gain register is written.
- R5: The register select encoding is: 0 = input code, 1 = gain, 2 = offset. A write with select 3 changes nothing.
- R6: A write changes only the registers of the channel given by wr_ch_i. All other channels keep their registers.
- R7: Output registers change only on the clock edge where load_i is high. At that edge all channels update together, and the new value is visible after that edge.
- R8: When load_i is high in the same cycle as a write, the loaded code includes the value being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| wr_ch_i | input | CH_AW | Channel addressed by the write |
| wr_sel_i | input | 2 | Register select (0 input, 1 gain, 2 offset, 3 none) |
| wr_data_i | input | RES_W | Write data |
| load_i | input | 1 | Transfer all trimmed codes to the output registers |
| dac_code_o | output | NUM_CH*RES_W | Output codes; channel k occupies bits [k*RES_W +: RES_W] |

## Verification
The trim function is exercised with four kinds of input:
- Default coefficients, which separate a true pass-through from any stray scaling.
- A fractional gain whose product lands exactly on half an LSB, which exposes rounding instead of truncation.
- Extreme input and offset pairs that push the sum below zero and above full scale, which show clamping rather than wraparound.
- An odd gain write beside an even one, which makes a missing LSB mask visible in the output.

Further cases write without loading, load in the same cycle as a write, and write a neighbouring channel. These separate correct buffering and channel addressing from leaks between stages or between channels.

// File: rtl/dac_trim_pkg.sv
package dac_trim_pkg;

  typedef enum logic [1:0] {
    SEL_INPUT  = 2'd0,
    SEL_GAIN   = 2'd1,
    SEL_OFFSET = 2'd2,
    SEL_NONE   = 2'd3
  } trim_sel_e;

endpackage

// File: rtl/dac_trim_calc.sv
module dac_trim_calc #(
  parameter int RES_W = 14,
  localparam int SUM_W = RES_W + 3
) (
  input  logic [RES_W-1:0]        x1_i,
  input  logic [RES_W-1:0]        gain_i,
  input  logic [RES_W-1:0]        offs_i,
  output logic signed [SUM_W-1:0] sum_o
);
  localparam int PROD_W = 2 * RES_W + 1;
  localparam logic [SUM_W-1:0] MID = SUM_W'(1) << (RES_W - 1);

  logic [RES_W:0]    gain_f;
  logic [PROD_W-1:0] prod;
  logic [RES_W:0]    scaled;

  assign gain_f = {1'b0, gain_i} + (RES_W + 1)'(2);
  assign prod   = PROD_W'(x1_i) * PROD_W'(gain_f);
  // truncating divide by 2^RES_W
  assign scaled = prod[PROD_W-1:RES_W];
  assign sum_o  = $signed({2'b00, scaled}) + $signed({3'b000, offs_i}) - $signed(MID);

endmodule

// File: rtl/dac_trim_sat.sv
module dac_trim_sat #(
  parameter int RES_W = 14,
  localparam int SUM_W = RES_W + 3
) (
  input  logic signed [SUM_W-1:0] sum_i,
  output logic [RES_W-1:0]        code_o
);
  always_comb begin
    if (sum_i[SUM_W-1])                 code_o = '0;
    else if (|sum_i[SUM_W-2:RES_W])     code_o = '1;
    else                                code_o = sum_i[RES_W-1:0];
  end
endmodule

// File: rtl/dac_trim_chan.sv
module dac_trim_chan
  import dac_trim_pkg::*;
#(
  parameter int RES_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_hit_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [RES_W-1:0] wr_data_i,
  input  logic             load_i,
  output logic [RES_W-1:0] dac_code_o
);
  localparam int SUM_W = RES_W + 3;
  localparam logic [RES_W-1:0] GAIN_MASK = ~RES_W'(1);
  localparam logic [RES_W-1:0] GAIN_DEF  = ~RES_W'(1);
  localparam logic [RES_W-1:0] OFF_DEF   = RES_W'(1) << (RES_W - 1);

  trim_sel_e sel;
  logic [RES_W-1:0] x1_q, m_q, c_q;
  logic [RES_W-1:0] x1_d, m_d, c_d;
  logic signed [SUM_W-1:0] sum;
  logic [RES_W-1:0] corr_code;
  logic [RES_W-1:0] dac_q;

  assign sel = trim_sel_e'(wr_sel_i);

  // write-merged view so a same-cycle load sees new data
  always_comb begin
    x1_d = x1_q;
    m_d  = m_q;
    c_d  = c_q;
    if (wr_hit_i) begin
      case (sel)
        SEL_INPUT:  x1_d = wr_data_i;
        SEL_GAIN:   m_d  = wr_data_i & GAIN_MASK;
        SEL_OFFSET: c_d  = wr_data_i;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q <= '0;
      m_q  <= GAIN_DEF;
      c_q  <= OFF_DEF;
    end else begin
      x1_q <= x1_d;
      m_q  <= m_d;
      c_q  <= c_d;
    end
  end

  dac_trim_calc #(.RES_W(RES_W)) u_calc (
    .x1_i   (x1_d),
    .gain_i (m_d),
    .offs_i (c_d),
    .sum_o  (sum)
  );

  dac_trim_sat #(.RES_W(RES_W)) u_sat (
    .sum_i  (sum),
    .code_o (corr_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dac_q <= '0;
    else if (load_i) dac_q <= corr_code;
  end

  assign dac_code_o = dac_q;

  p_unity_default_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_hit_i && m_q == GAIN_DEF && c_q == OFF_DEF) |-> corr_code == x1_q);

  p_gain_lsb_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && sel == SEL_GAIN) |=> m_q == ($past(wr_data_i) & GAIN_MASK));

  p_sel_none_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && sel == SEL_NONE) |=> ($stable(x1_q) && $stable(m_q) && $stable(c_q)));

  p_no_stray_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit_i |=> ($stable(x1_q) && $stable(m_q) && $stable(c_q)));

  p_hold_without_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(dac_q));

  p_load_takes_new_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> dac_q == $past(corr_code));

endmodule

// File: rtl/dac_trim_top.sv
module dac_trim_top #(
  parameter int NUM_CH = 16,
  parameter int RES_W  = 14,
  localparam int CH_AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [CH_AW-1:0]        wr_ch_i,
  input  logic [1:0]              wr_sel_i,
  input  logic [RES_W-1:0]        wr_data_i,
  input  logic                    load_i,
  output logic [NUM_CH*RES_W-1:0] dac_code_o
);
  logic [NUM_CH-1:0] wr_hit;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign wr_hit[ch] = wr_en_i && (wr_ch_i == CH_AW'(ch));

    dac_trim_chan #(.RES_W(RES_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_hit_i   (wr_hit[ch]),
      .wr_sel_i   (wr_sel_i),
      .wr_data_i  (wr_data_i),
      .load_i     (load_i),
      .dac_code_o (dac_code_o[ch*RES_W +: RES_W])
    );
  end

  p_single_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_hit));

endmodule

// File: tb/dac_trim_top_tb.sv
module dac_trim_top_tb;
  localparam int  NUM_CH  = 16;
  localparam int  RES_W   = 14;
  localparam int  CH_AW   = 4;
  localparam time CLK_PER = 10ns;
  localparam int  MAXC    = (1 << RES_W) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [CH_AW-1:0] wr_ch = '0;
  logic [1:0] wr_sel = '0;
  logic [RES_W-1:0] wr_data = '0;
  logic load = 1'b0;
  logic [NUM_CH*RES_W-1:0] dac_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int sx1[NUM_CH], sm[NUM_CH], sc[NUM_CH], sdac[NUM_CH];

  always #(CLK_PER/2) clk = ~clk;

  dac_trim_top #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .load_i(load), .dac_code_o(dac_code)
  );

  function automatic int model(int x1, int m, int c);
    int s;
    s = ((x1 * (m + 2)) >> RES_W) + c - (1 << (RES_W - 1));
    if (s < 0) s = 0;
    if (s > MAXC) s = MAXC;
    return s;
  endfunction

  function automatic int out_of(int ch);
    return int'(dac_code[ch*RES_W +: RES_W]);
  endfunction

  task automatic check(string req, int ch, int exp);
    n_chk++;
    if (out_of(ch) != exp) begin
      n_fail++;
      $display("FAIL %s ch%0d actual=%0d expected=%0d", req, ch, out_of(ch), exp);
    end
  endtask

  task automatic check_all(string req);
    for (int k = 0; k < NUM_CH; k++) check(req, k, sdac[k]);
  endtask

  task automatic shadow_reset();
    for (int k = 0; k < NUM_CH; k++) begin
      sx1[k] = 0; sm[k] = MAXC - 1; sc[k] = 1 << (RES_W - 1); sdac[k] = 0;
    end
  endtask

  // one cycle: optional write plus optional load; returns at the negedge after
  task automatic cyc(bit we, int ch, int sel, int data, bit ld);
    @(negedge clk);
    wr_en = we; wr_ch = CH_AW'(ch); wr_sel = 2'(sel); wr_data = RES_W'(data); load = ld;
    @(posedge clk);
    if (we) begin
      case (sel)
        0: sx1[ch] = data;
        1: sm[ch]  = data & ~1;
        2: sc[ch]  = data;
        default: ;
      endcase
    end
    if (ld) for (int k = 0; k < NUM_CH; k++) sdac[k] = model(sx1[k], sm[k], sc[k]);
    @(negedge clk);
    wr_en = 1'b0; load = 1'b0;
  endtask

  task automatic t_reset();
    shadow_reset();
    check_all("R2 reset outputs");
    cyc(0, 0, 0, 0, 1);
    check_all("R2 load after reset");
    cyc(1, 3, 0, 1234, 0);
    cyc(0, 0, 0, 0, 1);
    check("R2 unity pass-through", 3, 1234);
  endtask

  task automatic t_formula();
    cyc(1, 0, 0, 'h3000, 0);
    cyc(1, 0, 1, 'h2000, 0);
    cyc(1, 0, 2, 'h2100, 1);
    check("R1 truncating half-LSB", 0, 6401);
    cyc(1, 1, 0, 5000, 0);
    cyc(1, 1, 1, 'h1000, 0);
    cyc(1, 1, 2, 'h1F00, 1);
    check("R1 quarter gain", 1, model(5000, 'h1000, 'h1F00));
    check_all("R1 all channels");
  endtask

  task automatic t_sat();
    cyc(1, 2, 0, 0, 0);
    cyc(1, 2, 2, 0, 1);
    check("R3 clamp low", 2, 0);
    cyc(1, 4, 0, MAXC, 0);
    cyc(1, 4, 2, MAXC, 1);
    check("R3 clamp high", 4, MAXC);
  endtask

  task automatic t_lsb();
    cyc(1, 6, 0, MAXC, 0);
    cyc(1, 6, 1, 'h2001, 0);
    cyc(1, 7, 0, MAXC, 0);
    cyc(1, 7, 1, 'h2000, 1);
    check("R4 odd gain masked", 6, 8193);
    check("R4 even gain", 7, 8193);
  endtask

  task automatic t_sel_none();
    cyc(1, 8, 0, 777, 1);
    check("R5 input select", 8, 777);
    cyc(1, 8, 3, 0, 1);
    check("R5 select 3 ignored", 8, 777);
  endtask

  task automatic t_indep();
    cyc(1, 9, 0, 4321, 1);
    check("R6 addressed channel", 9, 4321);
    check_all("R6 neighbours unchanged");
  endtask

  task automatic t_hold();
    cyc(1, 10, 0, 2222, 0);
    check("R7 no load holds", 10, 0);
    cyc(1, 11, 0, 3333, 0);
    check("R7 no load holds", 11, 0);
    cyc(0, 0, 0, 0, 1);
    check("R7 simultaneous", 10, 2222);
    check("R7 simultaneous", 11, 3333);
  endtask

  task automatic t_same_cycle();
    cyc(1, 12, 0, 9999, 1);
    check("R8 same-cycle input", 12, 9999);
    cyc(1, 12, 2, 'h2010, 1);
    check("R8 same-cycle offset", 12, 9999 + 16);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    shadow_reset();
    check_all("R2 during reset");
    rst_ni = 1'b1;
    t_reset();
    t_formula();
    t_sat();
    t_lsb();
    t_sel_none();
    t_indep();
    t_hold();
    t_same_cycle();
    check_all("R7 final state");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule